// File: doc/BRIEF.md
# Character Display Buffer with Left and Right Entry

This block holds the characters of a sixteen-position display and loads them one at a time from a host write port. Display scan logic reads any position through an address input. The read path is combinational, so the scan logic sees a stored character as soon as the clock edge that writes it has passed.

There are two entry modes. In left entry, characters go into successive slots starting at the leftmost position, which is position 0. A write pointer steps through the slots and wraps around. In right entry, the buffer works like a calculator readout. Every write moves the whole row one slot to the left, drops the leftmost character, and puts the new character in the rightmost slot.

A clear command blanks the row. Switching mode sends the pointer back to the first slot and leaves the characters in place.

Top module: `dispbuf_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every position becomes the blank code 0x20, the write pointer goes to 0 and the stored mode goes to left entry.
- R2: `rd_char` always shows the character stored at position `rd_addr`, with no clock delay. A write becomes visible right after the edge that stores it.
- R3: In left entry (`mode_right`=0), a write stores `wr_char` at the pointer position and then moves the pointer up by one. The first write after a clear lands at position 0 (the leftmost slot), and later writes go to positions 1, 2 and so on.
- R4: In left entry, the pointer wraps from 15 to 0, so the seventeenth write after a clear overwrites position 0.
- R5: In right entry (`mode_right`=1), every write moves position i+1 into position i for i from 0 to 14, drops the old position 0 and stores `wr_char` at position 15.
- R6: In right entry, the first character written after a clear appears at position 15, and positions 0 to 14 stay blank.
- R7: `clr` blanks all positions to 0x20 and sets the pointer to 0. If `wr_en` is high in the same cycle, that write is dropped.
- R8: A change of `mode_right` between cycles sets the pointer to 0 and leaves the buffer contents unchanged. A left-entry write in the same cycle as the change goes to position 0.
- R9: In a cycle with no write, no clear and no mode change, the contents and the pointer stay as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Character write strobe |
| wr_char | input | 8 | Character to write |
| mode_right | input | 1 | Entry mode: 0 selects left entry, 1 selects right entry |
| clr | input | 1 | Clear command |
| rd_addr | input | 4 | Position read by the scan logic |
| rd_char | output | 8 | Character stored at `rd_addr` |

## Verification
A write, a clear or a mode change takes effect at the clock edge where it is sampled. Because the read path has no register, the result is already on `rd_char` in the half cycle that follows that edge. The bench drives each command on a falling edge, applies it to its own model at the next rising edge, and then drops the command lines. It reads back all sixteen positions while the block is idle, which R9 keeps steady, so the timing of the address changes cannot affect any result. The pointer is never read directly. Its value is inferred from where the next left-entry write lands.

// File: rtl/dispbuf_pkg.sv
package dispbuf_pkg;
  typedef enum logic {
    ENTRY_LEFT  = 1'b0,
    ENTRY_RIGHT = 1'b1
  } entry_mode_e;
endpackage

// File: rtl/dispbuf_ptr.sv
module dispbuf_ptr #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          mode_chg,
  input  logic          adv,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] ptr_eff
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // a mode change restarts entry at the first slot in the same cycle
  assign ptr_eff = mode_chg ? '0 : ptr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= (ptr_eff == LAST) ? '0 : ptr_eff + 1'b1;
    end else if (mode_chg) begin
      ptr_q <= '0;
    end
  end
endmodule

// File: rtl/dispbuf_cells.sv
module dispbuf_cells #(
  parameter int DEPTH = 16,
  parameter int CW = 8,
  parameter logic [CW-1:0] BLANK = 8'h20,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      wr_left,
  input  logic                      wr_right,
  input  logic [AW-1:0]             wr_idx,
  input  logic [CW-1:0]             wr_char,
  output logic [DEPTH-1:0][CW-1:0]  cells
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [CW-1:0] shift_in;
    if (i == DEPTH - 1) begin : g_tail
      assign shift_in = wr_char;
    end else begin : g_body
      assign shift_in = cells[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        cells[i] <= BLANK;
      end else if (wr_right) begin
        cells[i] <= shift_in;
      end else if (wr_left && (wr_idx == AW'(i))) begin
        cells[i] <= wr_char;
      end
    end
  end
endmodule

// File: rtl/dispbuf_entry_ctrl.sv
module dispbuf_entry_ctrl #(
  parameter int DEPTH = 16,
  parameter int CW = 8,
  parameter logic [CW-1:0] BLANK = 8'h20,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_char,
  input  logic          mode_right,
  input  logic          clr,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_char
);
  import dispbuf_pkg::*;

  entry_mode_e              mode_q;
  logic                     mode_chg;
  logic                     wr_left;
  logic                     wr_right;
  logic [AW-1:0]            ptr_q;
  logic [AW-1:0]            ptr_eff;
  logic [DEPTH-1:0][CW-1:0] cells;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= ENTRY_LEFT;
    else     mode_q <= entry_mode_e'(mode_right);
  end

  assign mode_chg = (entry_mode_e'(mode_right) != mode_q);
  assign wr_left  = wr_en && !clr && (entry_mode_e'(mode_right) == ENTRY_LEFT);
  assign wr_right = wr_en && !clr && (entry_mode_e'(mode_right) == ENTRY_RIGHT);

  dispbuf_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .mode_chg (mode_chg),
    .adv      (wr_left),
    .ptr_q    (ptr_q),
    .ptr_eff  (ptr_eff)
  );

  dispbuf_cells #(.DEPTH(DEPTH), .CW(CW), .BLANK(BLANK)) u_cells (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .wr_left  (wr_left),
    .wr_right (wr_right),
    .wr_idx   (ptr_eff),
    .wr_char  (wr_char),
    .cells    (cells)
  );

  assign rd_char = cells[rd_addr];
endmodule

// File: rtl/dispbuf_entry_ctrl_chk.sv
module dispbuf_entry_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int CW = 8,
  parameter logic [CW-1:0] BLANK = 8'h20,
  localparam int AW = $clog2(DEPTH)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [CW-1:0]            wr_char,
  input logic                     mode_right,
  input logic                     clr,
  input logic                     mode_bit,
  input logic [AW-1:0]            ptr_q,
  input logic [AW-1:0]            ptr_eff,
  input logic [DEPTH-1:0][CW-1:0] cells
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  p_reset_blank_r1: assert property (@(posedge clk)
    rst |=> (ptr_q == '0) && (cells == {DEPTH{BLANK}}));

  p_left_store_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr && !mode_right) |=> cells[$past(ptr_eff)] == $past(wr_char));

  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr && !mode_right && ptr_eff == LAST) |=> ptr_q == '0);

  p_right_shift_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr && mode_right) |=>
      (cells[DEPTH-1] == $past(wr_char)) && (cells[0] == $past(cells[1])));

  p_clear_blank_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr_q == '0) && (cells == {DEPTH{BLANK}}));

  p_mode_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr && !wr_en && (mode_right != mode_bit)) |=> (ptr_q == '0) && $stable(cells));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr && !wr_en && (mode_right == mode_bit)) |=> $stable(cells) && $stable(ptr_q));
endmodule

bind dispbuf_entry_ctrl dispbuf_entry_ctrl_chk #(
  .DEPTH(DEPTH), .CW(CW), .BLANK(BLANK)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_char    (wr_char),
  .mode_right (mode_right),
  .clr        (clr),
  .mode_bit   (mode_q),
  .ptr_q      (ptr_q),
  .ptr_eff    (ptr_eff),
  .cells      (cells)
);

// File: tb/dispbuf_entry_ctrl_test.sv
`timescale 1ns/1ps
module dispbuf_entry_ctrl_test;
  localparam int DEPTH = 16;
  localparam logic [7:0] BLANK = 8'h20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_char = 8'h00;
  logic       mode_right = 1'b0;
  logic       clr = 1'b0;
  logic [3:0] rd_addr = 4'd0;
  logic [7:0] rd_char;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_mem [DEPTH];
  int         m_ptr;
  logic       m_mode;

  always #5 clk = ~clk;

  dispbuf_entry_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char),
    .mode_right(mode_right), .clr(clr), .rd_addr(rd_addr), .rd_char(rd_char)
  );

  task automatic model_step(input logic w, input logic [7:0] c, input logic cl, input logic md);
    logic chg;
    int   eff;
    chg = (md != m_mode);
    m_mode = md;
    if (cl) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = BLANK;
      m_ptr = 0;
    end else begin
      eff = chg ? 0 : m_ptr;
      if (chg) m_ptr = 0;
      if (w) begin
        if (md) begin
          for (int i = 0; i < DEPTH - 1; i++) m_mem[i] = m_mem[i+1];
          m_mem[DEPTH-1] = c;
        end else begin
          m_mem[eff] = c;
          m_ptr = (eff + 1) % DEPTH;
        end
      end
    end
  endtask

  task automatic cycle(input logic w, input logic [7:0] c, input logic cl, input logic md);
    @(negedge clk);
    wr_en = w; wr_char = c; clr = cl; mode_right = md;
    @(posedge clk);
    model_step(w, c, cl, md);
    @(negedge clk);
    wr_en = 1'b0; clr = 1'b0;
  endtask

  // reads every position while idle; R9 keeps the contents steady across edges
  task automatic sweep(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = 4'(i);
      #1;
      checks++;
      if (rd_char !== m_mem[i]) begin
        errors++;
        $display("FAIL %s pos %0d: actual %h expected %h", tag, i, rd_char, m_mem[i]);
      end
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = BLANK;
    m_ptr = 0;
    m_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    sweep("R1 reset blank");

    // left entry fill from position 0
    for (int k = 0; k < 5; k++) cycle(1'b1, 8'h41 + 8'(k), 1'b0, 1'b0);
    sweep("R3 left fill");

    // continue to 17 writes: wrap overwrites position 0
    for (int k = 5; k < 17; k++) cycle(1'b1, 8'h41 + 8'(k), 1'b0, 1'b0);
    sweep("R4 pointer wrap");

    // clear with a simultaneous write: write dropped
    cycle(1'b1, 8'h5A, 1'b1, 1'b0);
    sweep("R7 clear drops write");

    // switch to right entry with a write in the same cycle
    cycle(1'b1, 8'h31, 1'b0, 1'b1);
    sweep("R6 first right char");

    for (int k = 0; k < 3; k++) cycle(1'b1, 8'h32 + 8'(k), 1'b0, 1'b1);
    sweep("R5 right shift");
    for (int k = 0; k < 20; k++) cycle(1'b1, 8'h61 + 8'(k), 1'b0, 1'b1);
    sweep("R5 right discard");

    // back to left without a write: contents kept, pointer to 0
    cycle(1'b0, 8'h00, 1'b0, 1'b0);
    sweep("R8 mode change keeps contents");
    cycle(1'b1, 8'h51, 1'b0, 1'b0);
    sweep("R8 pointer restart");

    // left write after a few left writes, then a mode change with write
    cycle(1'b1, 8'h52, 1'b0, 1'b0);
    cycle(1'b1, 8'hF0, 1'b0, 1'b1);
    cycle(1'b1, 8'h0F, 1'b0, 1'b0);
    sweep("R8 write with mode change");

    repeat (5) @(negedge clk);
    sweep("R9 idle hold");

    // near-exhaustive: both modes, 1 to 20 writes after a clear
    for (int md = 0; md < 2; md++) begin
      for (int n = 1; n <= 20; n++) begin
        cycle(1'b0, 8'h00, 1'b1, 1'(md));
        for (int k = 0; k < n; k++) cycle(1'b1, 8'(n * 7 + k * 13 + md), 1'b0, 1'(md));
        sweep(md ? "R2 R5 right sweep" : "R2 R3 left sweep");
      end
    end

    // reset mid-run returns to blank
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = BLANK;
    m_ptr = 0; m_mode = 1'b0;
    mode_right = 1'b0;
    @(negedge clk);
    sweep("R1 reset mid-run");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule